// File: doc/BRIEF.md
# Dual-Entry Update Partial-Product Table

This block holds the partial-product table of one tap group in a multiplier-free adaptive filter built on distributed arithmetic. The table has one entry per pattern of R address bits. Each bit of the address comes from one tap of the group. A run starts with one `start` pulse. The block then walks the bit planes of the current input words and returns one partial product per clock. An accumulator outside the block shifts these values and adds them up.

While the reads go on, the block adapts the table with the error of the previous sample, so the update never waits for the current output. The update address comes from the delayed input words and walks its bit planes in the opposite order to the reads. Each update writes two entries in the same cycle: the entry at the update address gets the positive error term, and the entry whose address differs only in its most significant bit gets the negative error term. Both error forms arrive already scaled, so the access path needs no negation. The two entries are fetched into registers one cycle before they are added, which keeps the adder out of the fetch path. A read that meets a write in the same cycle returns the newly written value.

Top module: `smda_dual_update`

## Requirements
- R1: During reset and in the first cycle after it, `pp_valid` and `busy` are low, and every table entry is zero.
- R2: A run reads plane s of the current words in cycle s of the run, for s = 0 up to B-1 (LSB first), and reports s on `pp_plane`. Tap word i is `cur_bits[i*B +: B]`, and its bit s forms address bit i, so tap R-1 supplies the address MSB.
- R3: Update step s of a run uses bit B-1-s of each delayed tap word `old_bits[i*B +: B]` (MSB first). Address bit i comes from tap word i.
- R4: Each update step adds `err_pos` to the entry at the update address and adds `err_neg` to the entry at that address with its MSB inverted, both modulo 2^W.
- R5: The read of plane s sees the table after update steps 0 to s-1 of the same run have been applied.
- R6: A `start` pulse while `busy` is high has no effect on the running sequence.
- R7: When `start` is sampled with `busy` low, `busy` is high from the next cycle on, and `pp_valid` is high one cycle later for exactly B cycles.
- R8: A new run may start in the first cycle with `busy` low. Its reads see every update of the previous run.
- R9: The tap words and both error terms are captured when a run starts. Changes to them during the run have no effect on that run.
- R10: `pp_data` holds its value while `pp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when `busy` is low |
| cur_bits | input | R*B | Current tap words, tap i at bits i*B and up |
| old_bits | input | R*B | Delayed tap words used for the update address |
| err_pos | input | W | Scaled error term for the addressed entry |
| err_neg | input | W | Scaled error term for the MSB-inverted entry |
| busy | output | 1 | A run is in progress |
| pp_valid | output | 1 | `pp_data` carries a partial product |
| pp_plane | output | clog2(B) | Bit plane of the current partial product |
| pp_data | output | W | Partial product read from the table |

## Verification
The hardest case to reach is a read of an entry that is being written in the same cycle. A related case is an update fetching an entry whose pending write has not yet landed. Both need the LSB-first read plane and the MSB-first update plane to hit the same entry, or its MSB partner, one step apart. The stimulus picks tap words whose bit patterns cause these collisions. It also includes back-to-back runs whose first read falls on the edge of the previous run's last write. It changes inputs and pulses `start` in the middle of a run to show that none of this reaches the outputs.

// File: rtl/smda_pkg.sv
package smda_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   function automatic int plane_bits(input int planes);
      return (planes > 1) ? $clog2(planes) : 1;
   endfunction

endpackage

// File: rtl/smda_seq.sv
module smda_seq
   import smda_pkg::*;
#(
   parameter int R  = 2,
   parameter int B  = 8,
   parameter int W  = 16,
   parameter int PW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [R*B-1:0] cur_bits,
   input  logic [R*B-1:0] old_bits,
   input  logic [W-1:0]   err_pos,
   input  logic [W-1:0]   err_neg,
   output logic           busy,
   output logic [PW-1:0]  step,
   output logic [R-1:0]   rd_addr,
   output logic [R-1:0]   up_addr,
   output logic [W-1:0]   ep_q,
   output logic [W-1:0]   en_q
);
   localparam logic [PW-1:0] LAST = PW'(B - 1);

   seq_state_t      state_q;
   logic [PW-1:0]   step_q;
   logic [PW-1:0]   rev_step;
   logic [R*B-1:0]  cur_q;
   logic [R*B-1:0]  old_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         step_q  <= '0;
         cur_q   <= '0;
         old_q   <= '0;
         ep_q    <= '0;
         en_q    <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_RUN;
                  step_q  <= '0;
                  cur_q   <= cur_bits;
                  old_q   <= old_bits;
                  ep_q    <= err_pos;
                  en_q    <= err_neg;
               end
            end
            default: begin
               if (step_q == LAST) begin
                  state_q <= SEQ_IDLE;
                  step_q  <= '0;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy     = (state_q == SEQ_RUN);
   assign step     = step_q;
   assign rev_step = LAST - step_q;

   for (genvar i = 0; i < R; i++) begin : g_tap
      logic [B-1:0] cur_word;
      logic [B-1:0] old_word;
      assign cur_word   = cur_q[i*B +: B];
      assign old_word   = old_q[i*B +: B];
      assign rd_addr[i] = cur_word[step_q];
      assign up_addr[i] = old_word[rev_step];
   end

endmodule

// File: rtl/smda_table.sv
module smda_table #(
   parameter int R       = 2,
   parameter int W       = 16,
   parameter bit PRELOAD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_en,
   input  logic [R-1:0] rd_addr,
   input  logic         up_en,
   input  logic [R-1:0] up_addr,
   input  logic [W-1:0] e_pos,
   input  logic [W-1:0] e_neg,
   output logic [W-1:0] rd_data
);
   localparam int           D     = 1 << R;
   localparam logic [R-1:0] MSB_M = R'(1 << (R - 1));

   logic [W-1:0] ent_q [D];
   logic         wr_en;
   logic [R-1:0] wr_a;
   logic [R-1:0] wr_b;
   logic [W-1:0] wr_va;
   logic [W-1:0] wr_vb;
   logic [D-1:0] hit_a;
   logic [D-1:0] hit_b;
   logic [W-1:0] rd_q;

   assign wr_b = wr_a ^ MSB_M;

   // write decoders: one for the addressed entry, one for its partner
   for (genvar j = 0; j < D; j++) begin : g_dec
      assign hit_a[j] = wr_en && (wr_a == R'(j));
      assign hit_b[j] = wr_en && (wr_b == R'(j));
   end

   // entry value as seen after the write of this cycle lands
   function automatic logic [W-1:0] look(input logic [R-1:0] x);
      if (hit_a[x]) return wr_va;
      if (hit_b[x]) return wr_vb;
      return ent_q[x];
   endfunction

   if (PRELOAD) begin : g_pre
      logic         pl_vld;
      logic [R-1:0] pl_a;
      logic [W-1:0] pl_va;
      logic [W-1:0] pl_vb;
      logic [W-1:0] pl_ep;
      logic [W-1:0] pl_en;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pl_vld <= 1'b0;
            pl_a   <= '0;
            pl_va  <= '0;
            pl_vb  <= '0;
            pl_ep  <= '0;
            pl_en  <= '0;
         end else begin
            pl_vld <= up_en;
            if (up_en) begin
               pl_a  <= up_addr;
               pl_va <= look(up_addr);
               pl_vb <= look(up_addr ^ MSB_M);
               pl_ep <= e_pos;
               pl_en <= e_neg;
            end
         end
      end

      assign wr_en = pl_vld;
      assign wr_a  = pl_a;
      assign wr_va = pl_va + pl_ep;
      assign wr_vb = pl_vb + pl_en;
   end else begin : g_direct
      assign wr_en = up_en;
      assign wr_a  = up_addr;
      assign wr_va = ent_q[up_addr] + e_pos;
      assign wr_vb = ent_q[up_addr ^ MSB_M] + e_neg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < D; j++) ent_q[j] <= '0;
      end else begin
         for (int j = 0; j < D; j++) begin
            if (hit_a[j])      ent_q[j] <= wr_va;
            else if (hit_b[j]) ent_q[j] <= wr_vb;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= look(rd_addr);
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/smda_dual_update.sv
module smda_dual_update
   import smda_pkg::*;
#(
   parameter int R       = 2,
   parameter int B       = 8,
   parameter int W       = 16,
   parameter bit PRELOAD = 1'b1,
   localparam int PW     = plane_bits(B)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [R*B-1:0] cur_bits,
   input  logic [R*B-1:0] old_bits,
   input  logic [W-1:0]   err_pos,
   input  logic [W-1:0]   err_neg,
   output logic           busy,
   output logic           pp_valid,
   output logic [PW-1:0]  pp_plane,
   output logic [W-1:0]   pp_data
);
   if (R < 1 || R > 10) begin : g_bad_r
      $error("smda_dual_update: R out of range");
   end
   if (B < 2) begin : g_bad_b
      $error("smda_dual_update: B must be at least 2");
   end
   if (W < 2) begin : g_bad_w
      $error("smda_dual_update: W must be at least 2");
   end

   logic          run;
   logic [PW-1:0] step;
   logic [R-1:0]  rd_addr;
   logic [R-1:0]  up_addr;
   logic [W-1:0]  ep_q;
   logic [W-1:0]  en_q;
   logic          vld_q;
   logic [PW-1:0] plane_q;

   smda_seq #(.R(R), .B(B), .W(W), .PW(PW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cur_bits (cur_bits),
      .old_bits (old_bits),
      .err_pos  (err_pos),
      .err_neg  (err_neg),
      .busy     (run),
      .step     (step),
      .rd_addr  (rd_addr),
      .up_addr  (up_addr),
      .ep_q     (ep_q),
      .en_q     (en_q)
   );

   smda_table #(.R(R), .W(W), .PRELOAD(PRELOAD)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (run),
      .rd_addr (rd_addr),
      .up_en   (run),
      .up_addr (up_addr),
      .e_pos   (ep_q),
      .e_neg   (en_q),
      .rd_data (pp_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         plane_q <= '0;
      end else begin
         vld_q <= run;
         if (run) plane_q <= step;
      end
   end

   assign busy     = run;
   assign pp_valid = vld_q;
   assign pp_plane = plane_q;

endmodule

// File: rtl/smda_dual_update_chk.sv
module smda_dual_update_chk #(
   parameter int B  = 8,
   parameter int W  = 16,
   parameter int PW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          pp_valid,
   input logic [PW-1:0] pp_plane,
   input logic [W-1:0]  pp_data
);
   localparam logic [PW-1:0] LAST = PW'(B - 1);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!pp_valid && !busy));

   // R7
   start_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !pp_valid) ##1 (pp_valid && pp_plane == '0));

   // R2
   plane_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && pp_plane != LAST) |=>
         (pp_valid && pp_plane == PW'($past(pp_plane) + 1'b1)));

   // R7
   valid_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && pp_plane == LAST) |=> !pp_valid);

   // R6
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && pp_valid && pp_plane != LAST) |=> pp_plane != '0);

   // R10
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pp_valid |-> $stable(pp_data));

endmodule

bind smda_dual_update smda_dual_update_chk #(.B(B), .W(W), .PW(PW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .pp_valid (pp_valid),
   .pp_plane (pp_plane),
   .pp_data  (pp_data)
);

// File: tb/sim_smda_dual_update.sv
module sim_smda_dual_update;
   localparam int R  = 2;
   localparam int B  = 8;
   localparam int W  = 16;
   localparam int PW = 3;
   localparam int D  = 1 << R;
   localparam int CLK_PERIOD = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [R*B-1:0] cur_bits = '0;
   logic [R*B-1:0] old_bits = '0;
   logic [W-1:0]   err_pos = '0;
   logic [W-1:0]   err_neg = '0;
   logic           busy;
   logic           pp_valid;
   logic [PW-1:0]  pp_plane;
   logic [W-1:0]   pp_data;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [W-1:0] mdl [D];

   always #(CLK_PERIOD/2) clk = ~clk;

   smda_dual_update #(.R(R), .B(B), .W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cur_bits(cur_bits),
      .old_bits(old_bits), .err_pos(err_pos), .err_neg(err_neg),
      .busy(busy), .pp_valid(pp_valid), .pp_plane(pp_plane), .pp_data(pp_data)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [R-1:0] addr_of(input logic [R*B-1:0] words, input int plane);
      logic [R-1:0] a;
      for (int i = 0; i < R; i++) a[i] = words[i*B + plane];
      return a;
   endfunction

   // one run; bench model applies updates in order, reads see updates 0..s-1 (R5)
   task automatic run(input logic [R*B-1:0] cur, input logic [R*B-1:0] old,
                      input logic [W-1:0] ep, input logic [W-1:0] en,
                      input bit disturb, input string req);
      logic [W-1:0] exp_rd [B];
      logic [R-1:0] ua;
      for (int s = 0; s < B; s++) begin
         exp_rd[s] = mdl[addr_of(cur, s)];            // R2
         ua = addr_of(old, B - 1 - s);                 // R3
         mdl[ua] = mdl[ua] + ep;                       // R4
         mdl[ua ^ R'(1 << (R-1))] = mdl[ua ^ R'(1 << (R-1))] + en;
      end
      cur_bits = cur; old_bits = old; err_pos = ep; err_neg = en;
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1 && pp_valid === 1'b0, {req, " R7 busy"}, {busy, pp_valid}, 2'b10);
      for (int s = 0; s < B; s++) begin
         if (disturb && s == 2) begin                  // R6 R9
            start = 1'b1; cur_bits = ~cur; old_bits = ~old;
            err_pos = ep ^ 16'h5A5A; err_neg = en + 16'h0101;
         end
         if (disturb && s == 4) start = 1'b0;
         @(posedge clk); @(negedge clk);
         chk(pp_valid === 1'b1 && pp_plane === PW'(s), {req, " R2 plane"}, pp_plane, s);
         chk(pp_data === exp_rd[s], {req, " R5 data"}, pp_data, exp_rd[s]);
      end
      start = 1'b0;
   endtask

   task automatic idle_check(input string req);
      logic [W-1:0] held;
      held = pp_data;
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); @(negedge clk);
         chk(pp_valid === 1'b0 && busy === 1'b0, {req, " R7 idle"}, {busy, pp_valid}, 0);
         chk(pp_data === held, {req, " R10 hold"}, pp_data, held);
      end
   endtask

   task automatic t_reset_state();
      for (int i = 0; i < D; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      chk(pp_valid === 1'b0 && busy === 1'b0, "R1 reset outputs", {busy, pp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pp_valid === 1'b0 && busy === 1'b0, "R1 after reset", {busy, pp_valid}, 0);
      // every entry read with zero errors: all zero
      run({8'b1100_1100, 8'b1010_1010}, '0, '0, '0, 1'b0, "R1 entries");
      idle_check("R1");
   endtask

   task automatic t_dual_update();
      // old taps all ones: update addr 3, partner 1; then reread every entry
      run(16'h0000, 16'hFFFF, 16'h0010, 16'hFFF0, 1'b0, "R4 first");
      run({8'b1100_1100, 8'b1010_1010}, '0, '0, '0, 1'b0, "R4 readback");
      idle_check("R4");
   endtask

   task automatic t_plane_orders();
      // reads LSB first, updates MSB first on distinct patterns (R2 R3)
      run({8'b0110_1001, 8'b0011_1100}, {8'b1000_0111, 8'b0101_0001},
          16'h0123, 16'hFEDD, 1'b0, "R3 mixed");
      run({8'b1111_0000, 8'b1001_0110}, {8'b0001_1110, 8'b1110_0010},
          16'h0040, 16'h0007, 1'b0, "R2 mixed");
      idle_check("R3");
   endtask

   task automatic t_collisions();
      // read plane s and update plane s-1 land on same entry or its partner (R5)
      run({8'b0101_0101, 8'b0000_0000}, {8'b1010_1010, 8'b0000_0000},
          16'h0100, 16'hFF00, 1'b0, "R5 partner");
      run({8'b1111_1111, 8'b1111_1111}, {8'b1111_1111, 8'b1111_1111},
          16'h0003, 16'h0005, 1'b0, "R5 same");
      // wrap modulo 2^W (R4)
      run({8'b1111_1111, 8'b0000_0000}, {8'b1111_1111, 8'b0000_0000},
          16'h7FFF, 16'h8001, 1'b0, "R4 wrap");
   endtask

   task automatic t_back_to_back();
      // second run starts in first idle cycle (R8)
      run({8'b0011_0011, 8'b0101_0101}, {8'b1100_1100, 8'b0110_0110},
          16'h0222, 16'hFDDE, 1'b0, "R8 first");
      run({8'b0101_0101, 8'b0011_0011}, {8'b0000_1111, 8'b1111_0000},
          16'h0011, 16'h0022, 1'b0, "R8 second");
      idle_check("R8");
   endtask

   task automatic t_disturb();
      // start and input changes mid-run must not matter (R6 R9)
      run({8'b1001_1001, 8'b0110_0011}, {8'b0111_0001, 8'b1011_1000},
          16'h0404, 16'hFBFC, 1'b1, "R6 R9 disturb");
      idle_check("R6");
      run({8'b1100_1100, 8'b1010_1010}, '0, '0, '0, 1'b0, "R9 readback");
      idle_check("R9");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_dual_update();
      t_plane_orders();
      t_collisions();
      t_back_to_back();
      t_disturb();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule